// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a four-beat burst access to a synchronous memory array. A starting address is captured into an address register when one of two active-low address strobes asks for it. One strobe comes from a cache controller and always loads. The other comes from a processor and loads only while chip enable is asserted. After a load, a two-bit beat counter replaces the two least significant address bits. The counter moves forward one beat on every clock edge where the advance input is low, and holds where it is high.

A static order-select input chooses how beats map onto the low address bits. In interleaved order, the low bits are the starting low bits XOR the beat count. In linear order, they are the starting low bits plus the beat count, modulo four. In both orders the fourth step returns to the starting beat. The upper address bits come straight from the address register.

The beat counter is a four-state machine with states BEAT_0, BEAT_1, BEAT_2 and BEAT_3. A load transition sends any state to BEAT_0. A step transition moves BEAT_0 to BEAT_1, BEAT_1 to BEAT_2, BEAT_2 to BEAT_3, and BEAT_3 back to BEAT_0 (the wrap). A hold transition keeps the current state. Reset also forces BEAT_0.

Top module: `burst_addr_seq`

## Requirements
- R1: When `ctrl_strobe_n` is 0 at a rising clock edge, the address register loads `addr_in`, whatever the value of `chip_en_n`. From the next cycle `word_addr` equals that address.
- R2: When `proc_strobe_n` is 0 at a rising edge, the address loads only if `chip_en_n` is also 0. With `chip_en_n` at 1, the processor strobe has no effect on `word_addr`.
- R3: On an edge with no load, `adv_n` = 0 moves the beat counter one step and `adv_n` = 1 leaves `word_addr` unchanged.
- R4: With `order_sel` = 1 (interleaved), `word_addr[1:0]` equals the starting low bits XOR the beat count. For a start of 01 the sequence is 01, 00, 11, 10. For a start of 10 it is 10, 11, 00, 01.
- R5: With `order_sel` = 0 (linear), `word_addr[1:0]` equals the starting low bits plus the beat count, modulo 4. For a start of 01 the sequence is 01, 10, 11, 00.
- R6: A step from the fourth beat (BEAT_3) returns the counter to BEAT_0. `word_addr` is then again the loaded starting address.
- R7: `word_addr[14:2]` always equals bits 14 to 2 of the most recently loaded address and stays unchanged while a burst steps.
- R8: A load sets the beat count to BEAT_0 on the same edge. A load takes priority over `adv_n` = 0, including in the middle of a burst.
- R9: A synchronous `rst` = 1 clears the address register and the beat count, so `word_addr` is 0 after the edge. Reset wins over a simultaneous load.
- R10: On an edge with no load condition, `addr_in` has no effect on `word_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | 15 | External starting address |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low, not gated by chip enable |
| proc_strobe_n | input | 1 | Processor address strobe, active low, gated by chip enable |
| chip_en_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Beat advance, active low |
| order_sel | input | 1 | Static beat order: 1 interleaved, 0 linear |
| word_addr | output | 15 | Internal array word address |

## Verification
The beat counter and the address register both feed `word_addr` directly, with no further pipeline stage. A wrong beat state therefore shows up in `word_addr[1:0]` in the first cycle after the faulty edge. A wrong load decision shows up in the upper bits in that same cycle. Wrap errors appear only on the fourth step of a burst, and order errors only on the second and fourth beats for some starting values. For that reason the stimulus walks full bursts from several starting low bits in both orders and checks every beat.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int BEAT_W = 2;
    localparam int BEATS  = 1 << BEAT_W;

    typedef enum logic [BEAT_W-1:0] {
        BEAT_0 = 2'd0,
        BEAT_1 = 2'd1,
        BEAT_2 = 2'd2,
        BEAT_3 = 2'd3
    } beat_e;

    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        logic load;
        logic step;
    } seq_ctl_t;

endpackage

// File: rtl/burst_load_decode.sv
module burst_load_decode
    import burst_seq_pkg::*;
(
    input  logic     ctrl_strobe_n,
    input  logic     proc_strobe_n,
    input  logic     chip_en_n,
    input  logic     adv_n,
    output seq_ctl_t ctl
);

    logic ctrl_load;
    logic proc_load;

    // Controller strobe ignores chip enable; processor strobe needs it.
    always_comb begin
        ctrl_load = ~ctrl_strobe_n;
        proc_load = ~proc_strobe_n & ~chip_en_n;
        ctl.load  = ctrl_load | proc_load;
        ctl.step  = ~ctl.load & ~adv_n;
    end

endmodule

// File: rtl/burst_beat_fsm.sv
module burst_beat_fsm
    import burst_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  seq_ctl_t          ctl,
    output logic [BEAT_W-1:0] beat_cnt
);

    beat_e state_q;
    beat_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BEAT_0;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: load, step (with wrap), hold
    always_comb begin
        state_d = state_q;
        if (ctl.load) begin
            state_d = BEAT_0;
        end else if (ctl.step) begin
            unique case (state_q)
                BEAT_0: state_d = BEAT_1;
                BEAT_1: state_d = BEAT_2;
                BEAT_2: state_d = BEAT_3;
                BEAT_3: state_d = BEAT_0;
                default: state_d = BEAT_0;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            BEAT_0: beat_cnt = 2'd0;
            BEAT_1: beat_cnt = 2'd1;
            BEAT_2: beat_cnt = 2'd2;
            BEAT_3: beat_cnt = 2'd3;
            default: beat_cnt = 2'd0;
        endcase
    end

endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= addr_in;
        end
    end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_seq_pkg::*;
(
    input  logic [BEAT_W-1:0] start_lo,
    input  logic [BEAT_W-1:0] beat_cnt,
    input  logic              order_sel,
    output logic [BEAT_W-1:0] addr_lo
);

    logic [BEAT_W-1:0] lo_interleave;
    logic [BEAT_W-1:0] lo_linear;

    // One XOR per low bit for interleaved order
    for (genvar g = 0; g < BEAT_W; g++) begin : g_xor
        assign lo_interleave[g] = start_lo[g] ^ beat_cnt[g];
    end

    // Linear order: modulo-BEATS add, the carry out drops naturally
    assign lo_linear = start_lo + beat_cnt;

    always_comb begin
        unique case (order_e'(order_sel))
            ORDER_INTERLEAVE: addr_lo = lo_interleave;
            ORDER_LINEAR:     addr_lo = lo_linear;
            default:          addr_lo = lo_linear;
        endcase
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ctrl_strobe_n,
    input  logic              proc_strobe_n,
    input  logic              chip_en_n,
    input  logic              adv_n,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] word_addr
);

    localparam int UPPER_W = ADDR_W - BEAT_W;

    seq_ctl_t          ctl;
    logic [ADDR_W-1:0] addr_q;
    logic [BEAT_W-1:0] beat_cnt;
    logic [BEAT_W-1:0] addr_lo;
    logic [UPPER_W-1:0] addr_hi;

    burst_load_decode u_decode (
        .ctrl_strobe_n (ctrl_strobe_n),
        .proc_strobe_n (proc_strobe_n),
        .chip_en_n     (chip_en_n),
        .adv_n         (adv_n),
        .ctl           (ctl)
    );

    burst_addr_reg #(.ADDR_W(ADDR_W)) u_areg (
        .clk     (clk),
        .rst     (rst),
        .load    (ctl.load),
        .addr_in (addr_in),
        .addr_q  (addr_q)
    );

    burst_beat_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .beat_cnt (beat_cnt)
    );

    burst_order_map u_map (
        .start_lo  (addr_q[BEAT_W-1:0]),
        .beat_cnt  (beat_cnt),
        .order_sel (order_sel),
        .addr_lo   (addr_lo)
    );

    assign addr_hi   = addr_q[ADDR_W-1:BEAT_W];
    assign word_addr = {addr_hi, addr_lo};

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_in,
    input logic              ctrl_strobe_n,
    input logic              proc_strobe_n,
    input logic              chip_en_n,
    input logic              adv_n,
    input logic              order_sel,
    input logic [ADDR_W-1:0] word_addr
);

    logic any_load;
    assign any_load = ~ctrl_strobe_n | (~proc_strobe_n & ~chip_en_n);

    assert_ctrl_load_R1: assert property (@(posedge clk) disable iff (rst)
        !ctrl_strobe_n |=> word_addr == $past(addr_in));

    assert_proc_load_R2: assert property (@(posedge clk) disable iff (rst)
        (!proc_strobe_n && !chip_en_n) |=> word_addr == $past(addr_in));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!any_load && adv_n) |=> $stable(word_addr));

    assert_interleave_toggle_R4: assert property (@(posedge clk) disable iff (rst)
        (!any_load && !adv_n && order_sel) |=> word_addr[0] != $past(word_addr[0]));

    assert_linear_step_R5: assert property (@(posedge clk) disable iff (rst)
        (!any_load && !adv_n && !order_sel)
        |=> word_addr[1:0] == 2'($past(word_addr[1:0]) + 2'd1));

    assert_upper_kept_R7: assert property (@(posedge clk) disable iff (rst)
        !any_load |=> word_addr[ADDR_W-1:2] == $past(word_addr[ADDR_W-1:2]));

    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> word_addr == '0);

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .addr_in       (addr_in),
    .ctrl_strobe_n (ctrl_strobe_n),
    .proc_strobe_n (proc_strobe_n),
    .chip_en_n     (chip_en_n),
    .adv_n         (adv_n),
    .order_sel     (order_sel),
    .word_addr     (word_addr)
);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;

    localparam int AW = 15;
    localparam int NV = 28;

    typedef struct packed {
        logic          ctrl_n;
        logic          proc_n;
        logic          ce_n;
        logic          adv_n;
        logic          order;
        logic [AW-1:0] addr;
        logic [AW-1:0] exp;
    } vec_t;

    // ctrl_n, proc_n, ce_n, adv_n, order, addr, expected word_addr after the edge
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b1,1'b1,1'b1,1'b1,15'h1235,15'h1235}, // 0  R1 load, CE off
        '{1'b1,1'b1,1'b1,1'b0,1'b1,15'h0000,15'h1234}, // 1  R4
        '{1'b1,1'b1,1'b1,1'b0,1'b1,15'h0000,15'h1237}, // 2  R4
        '{1'b1,1'b1,1'b1,1'b0,1'b1,15'h0000,15'h1236}, // 3  R4
        '{1'b1,1'b1,1'b1,1'b0,1'b1,15'h0000,15'h1235}, // 4  R6 wrap
        '{1'b1,1'b1,1'b1,1'b1,1'b1,15'h0000,15'h1235}, // 5  R3 hold
        '{1'b0,1'b1,1'b0,1'b1,1'b0,15'h2AF5,15'h2AF5}, // 6  R1
        '{1'b1,1'b1,1'b0,1'b0,1'b0,15'h0000,15'h2AF6}, // 7  R5
        '{1'b1,1'b1,1'b0,1'b0,1'b0,15'h0000,15'h2AF7}, // 8  R5
        '{1'b1,1'b1,1'b0,1'b1,1'b0,15'h0000,15'h2AF7}, // 9  R3 hold
        '{1'b1,1'b1,1'b0,1'b0,1'b0,15'h0000,15'h2AF4}, // 10 R5
        '{1'b1,1'b1,1'b0,1'b0,1'b0,15'h0000,15'h2AF5}, // 11 R6 wrap
        '{1'b1,1'b0,1'b1,1'b1,1'b0,15'h0003,15'h2AF5}, // 12 R2 gated off
        '{1'b1,1'b0,1'b1,1'b0,1'b0,15'h0003,15'h2AF6}, // 13 R2 gated off, steps
        '{1'b1,1'b0,1'b0,1'b1,1'b0,15'h7FFE,15'h7FFE}, // 14 R2 load
        '{1'b1,1'b1,1'b0,1'b0,1'b0,15'h0000,15'h7FFF}, // 15 R7
        '{1'b0,1'b1,1'b1,1'b0,1'b0,15'h0102,15'h0102}, // 16 R8 load over advance
        '{1'b1,1'b1,1'b1,1'b0,1'b0,15'h0000,15'h0103}, // 17 R5
        '{1'b1,1'b1,1'b1,1'b0,1'b0,15'h0000,15'h0100}, // 18 R7 no carry into upper
        '{1'b1,1'b1,1'b1,1'b0,1'b0,15'h0000,15'h0101}, // 19 R5
        '{1'b1,1'b1,1'b1,1'b0,1'b0,15'h0000,15'h0102}, // 20 R6 wrap
        '{1'b0,1'b1,1'b0,1'b1,1'b1,15'h4442,15'h4442}, // 21 R1
        '{1'b1,1'b1,1'b0,1'b0,1'b1,15'h0000,15'h4443}, // 22 R4
        '{1'b1,1'b1,1'b0,1'b0,1'b1,15'h0000,15'h4440}, // 23 R4
        '{1'b1,1'b1,1'b0,1'b0,1'b1,15'h0000,15'h4441}, // 24 R4
        '{1'b1,1'b1,1'b0,1'b1,1'b1,15'h1111,15'h4441}, // 25 R10 address ignored
        '{1'b0,1'b1,1'b1,1'b0,1'b1,15'h0007,15'h0007}, // 26 R8 mid-burst load
        '{1'b1,1'b1,1'b1,1'b0,1'b1,15'h0000,15'h0006}  // 27 R8 count restarted
    };

    function automatic string row_req(int i);
        case (i)
            0, 6, 21:                return "R1";
            12, 13, 14:              return "R2";
            5, 9:                    return "R3";
            1, 2, 3, 22, 23, 24:     return "R4";
            7, 8, 10, 17, 19:        return "R5";
            4, 11, 20:               return "R6";
            15, 18:                  return "R7";
            16, 26, 27:              return "R8";
            default:                 return "R10";
        endcase
    endfunction

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic          ctrl_strobe_n = 1'b1;
    logic          proc_strobe_n = 1'b1;
    logic          chip_en_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          order_sel = 1'b0;
    logic [AW-1:0] word_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .addr_in       (addr_in),
        .ctrl_strobe_n (ctrl_strobe_n),
        .proc_strobe_n (proc_strobe_n),
        .chip_en_n     (chip_en_n),
        .adv_n         (adv_n),
        .order_sel     (order_sel),
        .word_addr     (word_addr)
    );

    task automatic check(string req, logic [AW-1:0] got, logic [AW-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s word_addr=%h expected=%h", req, got, exp);
        end
    endtask

    // Drive at the falling edge, sample 1 ns after the following rising edge
    task automatic drive(logic r, logic c, logic p, logic e, logic a, logic o, logic [AW-1:0] ad);
        @(negedge clk);
        rst = r; ctrl_strobe_n = c; proc_strobe_n = p; chip_en_n = e;
        adv_n = a; order_sel = o; addr_in = ad;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R9", word_addr, '0);

        for (int i = 0; i < NV; i++) begin
            drive(1'b0, VEC[i].ctrl_n, VEC[i].proc_n, VEC[i].ce_n,
                  VEC[i].adv_n, VEC[i].order, VEC[i].addr);
            check(row_req(i), word_addr, VEC[i].exp);
        end

        // R9: reset wins over a simultaneous controller load
        drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 15'h5555);
        check("R9", word_addr, '0);

        // R9: reset in mid-burst clears the beat count
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 15'h0001);
        check("R1", word_addr, 15'h0001);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 15'h0000);
        check("R5", word_addr, 15'h0002);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 15'h0000);
        check("R9", word_addr, '0);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 15'h0000);
        check("R9", word_addr, 15'h0001);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule